// File: doc/BRIEF.md
# Automatic Media Port Selector

This block decides which of two media ports a 10 Mb/s Ethernet transceiver uses: the twisted-pair (TP) port or the attachment-unit (AU) port. It has two modes, chosen by `auto_mode_i`. In manual mode a shared bidirectional board pin is read as an input and its level names the port. In automatic mode the block makes the choice itself from the twisted-pair receiver's link-pulse and frame-detect strobes, and it drives the shared pin as an indicator of the chosen port.

In automatic mode, every valid link pulse or valid frame strobe selects twisted-pair. The block returns to the attachment-unit port when no strobe has arrived for `TIMEOUT_CYC` clock cycles. Link-integrity checking can be turned off, and then this silence fallback does not happen. A port change never cuts a frame. While transmit or receive activity is in progress, any change waits, and it takes effect on the first idle cycle. A diagnostic loopback request has no influence on the choice.

The selection state machine has four states:
- `ST_AUI`: the attachment-unit port is selected and no change is wanted.
- `ST_TP`: the twisted-pair port is selected and no change is wanted.
- `ST_TO_TP`: the attachment-unit port is still selected, and twisted-pair is wanted but blocked by activity.
- `ST_TO_AUI`: twisted-pair is still selected, and the attachment-unit port is wanted but blocked by activity.

The transitions are:
- `go_tp`: from `ST_AUI` or `ST_TO_TP` to `ST_TP`, when twisted-pair is wanted and the line is idle.
- `go_aui`: from `ST_TP` or `ST_TO_AUI` to `ST_AUI`, when the attachment-unit port is wanted and the line is idle.
- `hold_tp`: from `ST_AUI` to `ST_TO_TP`, when twisted-pair is wanted while busy.
- `hold_aui`: from `ST_TP` to `ST_TO_AUI`, when the attachment-unit port is wanted while busy.
- `cancel`: from `ST_TO_TP` back to `ST_AUI`, or from `ST_TO_AUI` back to `ST_TP`, when the wish reverts before the line goes idle.

Top module: `media_port_sel`

## Requirements
- R1: A synchronous reset selects the attachment-unit port (`tp_sel_o` = 0). While reset is high, `port_pin_oe` is 0.
- R2: `port_pin_oe` is 1 exactly when `auto_mode_i` is 1 and reset is low.
- R3: In manual mode (`auto_mode_i` = 0) with the line idle, a high pin level selects twisted-pair and a low level selects the attachment-unit port. The change appears `SYNC_STAGES` + 1 clock edges after the pin changes.
- R4: In automatic mode, a link-pulse or frame-detect strobe selects twisted-pair at the next clock edge when the line is idle.
- R5: While the pin is driven, `port_pin_o` is 1 for twisted-pair and 0 for the attachment-unit port.
- R6: In automatic mode with link checking enabled, suppose the last strobe was sampled at edge t and no further strobe arrives. The selection falls back to the attachment-unit port at edge t + `TIMEOUT_CYC` + 1, provided the line is idle.
- R7: With `link_chk_dis_i` = 1, silence never causes a fallback.
- R8: The selection never changes at an edge where `tx_busy_i` or `rx_busy_i` was sampled high. A pending change is applied at the first idle edge, unless the wanted port has reverted before then.
- R9: `loopback_i` has no effect on the selection.
- R10: In automatic mode, the level on `port_pin_i` has no effect on the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_mode_i | input | 1 | 1 = automatic selection, 0 = manual selection from the pin |
| port_pin_i | input | 1 | Level read from the shared pin (1 = TP, 0 = AU) |
| port_pin_o | output | 1 | Level driven onto the shared pin (1 = TP active) |
| port_pin_oe | output | 1 | Tri-state enable for the shared pin |
| link_pulse_i | input | 1 | One-cycle strobe for a valid link pulse on the TP receive pair |
| frame_det_i | input | 1 | One-cycle strobe for a valid frame on the TP receive pair |
| link_chk_dis_i | input | 1 | 1 = link-integrity checking off (no silence fallback) |
| loopback_i | input | 1 | Diagnostic loopback request |
| tx_busy_i | input | 1 | Transmit activity in progress |
| rx_busy_i | input | 1 | Receive activity in progress |
| tp_sel_o | output | 1 | Selected port: 1 = twisted-pair, 0 = attachment-unit |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 20 and `SYNC_STAGES` = 2. The short timeout lets the bench reach the silence fallback many times, and also the cases where a strobe lands one cycle before expiry or where expiry happens while the line is busy. With two synchronizer stages, the manual-mode latency is short enough to check pin changes that arrive just before activity starts and pending changes that are cancelled.

// File: rtl/msel_pkg.sv
package msel_pkg;
    typedef enum logic [1:0] {
        ST_AUI    = 2'd0,
        ST_TP     = 2'd1,
        ST_TO_TP  = 2'd2,
        ST_TO_AUI = 2'd3
    } sel_state_t;
endpackage

// File: rtl/msel_sync.sv
module msel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b0;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/msel_silence_timer.sv
module msel_silence_timer #(
    parameter int TIMEOUT_CYC = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic activity,
    output logic silent
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (activity)    cnt <= '0;
        else if (cnt < LIMIT) cnt <= cnt + 1'b1;
    end

    assign silent = (cnt == LIMIT);
endmodule

// File: rtl/msel_fsm.sv
module msel_fsm
    import msel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic auto_mode,
    input  logic manual_tp,
    input  logic activity,
    input  logic silent,
    input  logic fallback_en,
    input  logic busy,
    output logic tp_sel
);
    sel_state_t state, state_nx;
    logic       target_tp;
    logic       want_tp;

    assign target_tp = (state == ST_TP) || (state == ST_TO_TP);

    always_comb begin
        if (!auto_mode)                want_tp = manual_tp;
        else if (activity)             want_tp = 1'b1;
        else if (silent && fallback_en) want_tp = 1'b0;
        else                           want_tp = target_tp;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_AUI:    if (want_tp)  state_nx = busy ? ST_TO_TP  : ST_TP;
            ST_TO_TP:  if (!want_tp) state_nx = ST_AUI;
                       else if (!busy) state_nx = ST_TP;
            ST_TP:     if (!want_tp) state_nx = busy ? ST_TO_AUI : ST_AUI;
            ST_TO_AUI: if (want_tp)  state_nx = ST_TP;
                       else if (!busy) state_nx = ST_AUI;
            default:   state_nx = ST_AUI;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_AUI;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_TP, ST_TO_AUI: tp_sel = 1'b1;
            default:          tp_sel = 1'b0;
        endcase
    end
endmodule

// File: rtl/media_port_sel.sv
module media_port_sel #(
    parameter int TIMEOUT_CYC = 5_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic auto_mode_i,
    input  logic port_pin_i,
    output logic port_pin_o,
    output logic port_pin_oe,
    input  logic link_pulse_i,
    input  logic frame_det_i,
    input  logic link_chk_dis_i,
    input  logic loopback_i,
    input  logic tx_busy_i,
    input  logic rx_busy_i,
    output logic tp_sel_o
);
    logic pin_s;
    logic activity;
    logic silent;
    logic sel;
    logic loop_unused;

    assign activity    = link_pulse_i | frame_det_i;
    assign loop_unused = loopback_i;

    msel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (port_pin_i),
        .q   (pin_s)
    );

    msel_silence_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .activity (activity),
        .silent   (silent)
    );

    msel_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .auto_mode   (auto_mode_i),
        .manual_tp   (pin_s),
        .activity    (activity),
        .silent      (silent),
        .fallback_en (~link_chk_dis_i),
        .busy        (tx_busy_i | rx_busy_i),
        .tp_sel      (sel)
    );

    assign tp_sel_o    = sel;
    assign port_pin_o  = sel;
    assign port_pin_oe = auto_mode_i & ~rst;
endmodule

// File: rtl/msel_checker.sv
module msel_checker (
    input logic clk,
    input logic rst,
    input logic auto_mode_i,
    input logic port_pin_oe,
    input logic link_pulse_i,
    input logic frame_det_i,
    input logic tx_busy_i,
    input logic rx_busy_i,
    input logic tp_sel_o
);
    a_r1_reset_selects_aui: assert property (@(posedge clk)
        rst |=> !tp_sel_o);

    a_r2_oe_needs_auto: assert property (@(posedge clk) disable iff (rst)
        !auto_mode_i |-> !port_pin_oe);

    a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (tx_busy_i || rx_busy_i) |=> $stable(tp_sel_o));

    a_r4_strobe_never_drops_tp: assert property (@(posedge clk) disable iff (rst)
        (auto_mode_i && (link_pulse_i || frame_det_i)) |=> !$fell(tp_sel_o));
endmodule

bind media_port_sel msel_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .auto_mode_i  (auto_mode_i),
    .port_pin_oe  (port_pin_oe),
    .link_pulse_i (link_pulse_i),
    .frame_det_i  (frame_det_i),
    .tx_busy_i    (tx_busy_i),
    .rx_busy_i    (rx_busy_i),
    .tp_sel_o     (tp_sel_o)
);

// File: tb/sim_media_port_sel.sv
module sim_media_port_sel;
    localparam int TO = 20;
    localparam int SS = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic auto_mode_i = 1'b0, port_pin_i = 1'b0, link_pulse_i = 1'b0, frame_det_i = 1'b0;
    logic link_chk_dis_i = 1'b0, loopback_i = 1'b0, tx_busy_i = 1'b0, rx_busy_i = 1'b0;
    logic port_pin_o, port_pin_oe, tp_sel_o;

    always #10 clk = ~clk;

    media_port_sel #(.TIMEOUT_CYC(TO), .SYNC_STAGES(SS)) u0 (
        .clk(clk), .rst(rst), .auto_mode_i(auto_mode_i), .port_pin_i(port_pin_i),
        .port_pin_o(port_pin_o), .port_pin_oe(port_pin_oe), .link_pulse_i(link_pulse_i),
        .frame_det_i(frame_det_i), .link_chk_dis_i(link_chk_dis_i), .loopback_i(loopback_i),
        .tx_busy_i(tx_busy_i), .rx_busy_i(rx_busy_i), .tp_sel_o(tp_sel_o)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R1";

    // behavioural reference: target port, current port, silence age, pin history
    int m_cur = 0, m_tgt = 0, m_age = 0;
    bit pin_hist[$];

    always @(posedge clk) begin
        int want;
        cycles++;
        if (rst) begin
            m_cur = 0; m_tgt = 0; m_age = 0;
            pin_hist.delete();
            for (int i = 0; i < SS; i++) pin_hist.push_back(1'b0);
        end else begin
            if (!auto_mode_i)                        want = int'(pin_hist[0]);
            else if (link_pulse_i || frame_det_i)    want = 1;
            else if (m_age >= TO && !link_chk_dis_i) want = 0;
            else                                     want = m_tgt;
            m_tgt = want;
            if (!(tx_busy_i || rx_busy_i)) m_cur = m_tgt;
            if (link_pulse_i || frame_det_i) m_age = 0;
            else if (m_age < TO)             m_age++;
            void'(pin_hist.pop_front());
            pin_hist.push_back(port_pin_i);
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        check("tp_sel", int'(tp_sel_o), m_cur);
        check("oe R2", int'(port_pin_oe), int'(auto_mode_i && !rst));
        if (port_pin_oe) check("pin value R5", int'(port_pin_o), m_cur);
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            link_pulse_i = 1'b0;
            frame_det_i  = 1'b0;
        end
    endtask

    task automatic pulse_link();
        @(posedge clk); #2; link_pulse_i = 1'b1; frame_det_i = 1'b0;
        @(posedge clk); #2; link_pulse_i = 1'b0;
    endtask

    task automatic pulse_frame();
        @(posedge clk); #2; frame_det_i = 1'b1; link_pulse_i = 1'b0;
        @(posedge clk); #2; frame_det_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        tag = "R1"; step(4);
        @(negedge clk);
        check("reset port R1", int'(tp_sel_o), 0);
        check("reset oe R1", int'(port_pin_oe), 0);
        @(posedge clk); #2; rst = 1'b0;

        tag = "R3"; port_pin_i = 1'b1; step(SS + 1);
        @(negedge clk); check("manual TP after SS+1 R3", int'(tp_sel_o), 1);
        port_pin_i = 1'b0; step(SS + 2);
        @(negedge clk); check("manual AUI R3", int'(tp_sel_o), 0);

        tag = "R8"; rx_busy_i = 1'b1; port_pin_i = 1'b1; step(8);
        @(negedge clk); check("held while rx busy R8", int'(tp_sel_o), 0);
        rx_busy_i = 1'b0; step(1);
        @(negedge clk); check("applied when idle R8", int'(tp_sel_o), 1);
        tx_busy_i = 1'b1; port_pin_i = 1'b0; step(6);
        port_pin_i = 1'b1; step(6);
        tx_busy_i = 1'b0; step(2);
        @(negedge clk); check("cancelled change R8", int'(tp_sel_o), 1);
        port_pin_i = 1'b0; step(5);

        tag = "R2"; auto_mode_i = 1'b1; step(2);
        tag = "R4"; pulse_link();
        @(negedge clk); check("link pulse TP R4", int'(tp_sel_o), 1);
        tag = "R6"; step(TO + 3);
        @(negedge clk); check("silence fallback R6", int'(tp_sel_o), 0);
        tag = "R4"; pulse_frame();
        @(negedge clk); check("frame TP R4", int'(tp_sel_o), 1);
        tag = "R6"; step(TO - 2); pulse_link(); step(TO - 2);
        @(negedge clk); check("late pulse keeps TP R6", int'(tp_sel_o), 1);
        step(6);
        tag = "R8"; pulse_link(); rx_busy_i = 1'b1; step(TO + 5);
        @(negedge clk); check("fallback blocked by busy R8", int'(tp_sel_o), 1);
        rx_busy_i = 1'b0; step(2);

        tag = "R7"; link_chk_dis_i = 1'b1; pulse_link(); step(3 * TO);
        @(negedge clk); check("no fallback when disabled R7", int'(tp_sel_o), 1);
        link_chk_dis_i = 1'b0; step(3);
        @(negedge clk); check("fallback once enabled R7", int'(tp_sel_o), 0);

        tag = "R9"; loopback_i = 1'b1; pulse_frame(); step(4);
        @(negedge clk); check("loopback no effect R9", int'(tp_sel_o), 1);
        step(TO); loopback_i = 1'b0;
        @(negedge clk); check("loopback fallback R9", int'(tp_sel_o), 0);

        tag = "R10";
        for (int k = 0; k < 6; k++) begin
            port_pin_i = ~port_pin_i; step(3);
        end
        @(negedge clk); check("pin ignored in auto R10", int'(tp_sel_o), 0);

        tag = "R2"; auto_mode_i = 1'b0; port_pin_i = 1'b1; step(SS + 2);
        @(negedge clk); check("oe released R2", int'(port_pin_oe), 0);
        tag = "R1"; rst = 1'b1; step(2);
        @(negedge clk); check("reset again R1", int'(tp_sel_o), 0);
        finish_run();
    end
endmodule